// File: doc/BRIEF.md
# Ordered Write Buffer with Load Forwarding

This block sits between one core's memory request port and a cache. Stores go into a small circular queue and the core carries on at once. The queue hands its oldest entry to the cache write port whenever the cache can take a write. Writes therefore reach the cache in the order the core issued them.

A load does not wait behind buffered stores to other addresses; it reads the cache directly. If one or more buffered stores target the load's address, the load returns the value of the most recent of them, so the core always observes its own writes. A fence request is held off until the queue has drained completely. The result is total store ordering for one core.

The cache read path is combinational: the block presents the load address on `rd_addr` and expects `rd_data` in the same cycle. Loads and fences complete in the cycle they are accepted.

Top module: `wbuf_tso`

## Requirements
- R1: After reset the buffer is empty: `sb_count` is 0, `sb_empty` is 1, `sb_full` is 0 and `cw_valid` is 0.
- R2: A store request (`req_op` = 2'b01) with fewer than DEPTH entries held is accepted with `req_ready` high in the same cycle, and `sb_count` rises by one at the next edge when nothing drains.
- R3: While DEPTH entries are held, `sb_full` is 1, a store request sees `req_ready` low and nothing is enqueued; the count never exceeds DEPTH.
- R4: `cw_valid` is high exactly when the buffer holds an entry, and it presents the oldest entry. That entry leaves at an edge where `cw_ready` is high. While `cw_ready` is low, address and data stay stable.
- R5: Buffered stores reach the cache write port in the order they were accepted.
- R6: A load (`req_op` = 2'b00) is always accepted. If no buffered entry has its address, it returns `rd_data` with `ld_hit` low, even while older stores to other addresses are pending.
- R7: A load whose address matches buffered entries returns the data of the youngest matching entry, with `ld_hit` high.
- R8: A fence (`req_op[1]` = 1) sees `req_ready` low while any entry is held, and high once the buffer is empty.
- R9: When a store is accepted in the same cycle that the oldest entry drains, `sb_count` is unchanged at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_op | input | 2 | 00 load, 01 store, 1x fence |
| req_addr | input | AW | Word address of load or store |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted this cycle |
| ld_valid | output | 1 | Load result valid this cycle |
| ld_data | output | DW | Load result |
| ld_hit | output | 1 | Load result came from the buffer |
| rd_addr | output | AW | Cache read address |
| rd_data | input | DW | Cache read data, same cycle |
| cw_valid | output | 1 | Write to cache offered |
| cw_addr | output | AW | Write address (oldest entry) |
| cw_data | output | DW | Write data (oldest entry) |
| cw_ready | input | 1 | Cache takes the write this cycle |
| sb_count | output | CNT_W | Entries held |
| sb_full | output | 1 | DEPTH entries held |
| sb_empty | output | 1 | No entries held |

## Verification
The hardest case to reach is a load that matches several buffered entries after the queue has wrapped around its storage. The youngest match may then sit at a lower physical index than an older one. The stimulus holds `cw_ready` low in periodic windows so that the queue fills. It then releases drains while stores keep landing on a small, colliding set of addresses, so the head pointer walks the whole ring while duplicates are present. Loads against this mix are compared with a bench-side queue, and every drained write is matched in order against the same queue.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_FENCE = 2'b10,
    OP_FENCX = 2'b11
  } req_op_e;

  // next slot in a ring of the given depth
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // physical slot holding the entry 'age' places after the head
  function automatic int unsigned ring_slot(int unsigned head, int unsigned age,
                                            int unsigned depth);
    return (head + age) % depth;
  endfunction

  // occupancy after one cycle of enqueue/dequeue
  function automatic int unsigned occ_after(int unsigned occ, bit push, bit pop);
    if (push && !pop) return occ + 1;
    if (pop && !push) return occ - 1;
    return occ;
  endfunction

endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
(
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic       full,
  input  logic       empty,
  output logic       req_ready,
  output logic       store_fire,
  output logic       load_fire,
  output logic       fence_fire
);
  logic is_load, is_store, is_fence;

  always_comb begin
    is_fence = req_op[1];
    is_store = !req_op[1] && req_op[0];
    is_load  = !req_op[1] && !req_op[0];
  end

  always_comb begin
    req_ready = 1'b0;
    if (req_valid) begin
      if (is_load)       req_ready = 1'b1;
      else if (is_store) req_ready = !full;
      else               req_ready = empty;
    end
  end

  assign store_fire = req_valid && is_store && req_ready;
  assign load_fire  = req_valid && is_load;
  assign fence_fire = req_valid && is_fence && req_ready;
endmodule

// File: rtl/wbuf_queue.sv
module wbuf_queue
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [$clog2(DEPTH)-1:0]   head_ptr,
  output logic [$clog2(DEPTH+1)-1:0] occ,
  output logic [DEPTH-1:0]           live,
  output logic [DEPTH-1:0][AW-1:0]   slot_addr,
  output logic [DEPTH-1:0][DW-1:0]   slot_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] occ_q;
  logic [DEPTH-1:0] live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
      live_q <= '0;
    end else begin
      if (push) begin
        live_q[tail_q] <= 1'b1;
        tail_q <= PTR_W'(ring_next(int'(tail_q), DEPTH));
      end
      if (pop) begin
        live_q[head_q] <= 1'b0;
        head_q <= PTR_W'(ring_next(int'(head_q), DEPTH));
      end
      occ_q <= CNT_W'(occ_after(int'(occ_q), push, pop));
    end
  end

  // payload storage needs no reset: live bits qualify it
  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[tail_q] <= push_addr;
      slot_data[tail_q] <= push_data;
    end
  end

  assign head_ptr = head_q;
  assign occ      = occ_q;
  assign live     = live_q;
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic [$clog2(DEPTH)-1:0] head_ptr,
  input  logic [DEPTH-1:0]         live,
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [DEPTH-1:0][DW-1:0] slot_data,
  input  logic [AW-1:0]            look_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0] match;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = live[g] && (slot_addr[g] == look_addr);
    end
  endgenerate

  // walk from oldest to youngest; later matches override earlier ones
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int a = 0; a < DEPTH; a++) begin
      if (match[PTR_W'(ring_slot(int'(head_ptr), a, DEPTH))]) begin
        hit      = 1'b1;
        hit_data = slot_data[PTR_W'(ring_slot(int'(head_ptr), a, DEPTH))];
      end
    end
  end
endmodule

// File: rtl/wbuf_tso.sv
module wbuf_tso
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [1:0]                 req_op,
  input  logic [AW-1:0]              req_addr,
  input  logic [DW-1:0]              req_wdata,
  output logic                       req_ready,
  output logic                       ld_valid,
  output logic [DW-1:0]              ld_data,
  output logic                       ld_hit,
  output logic [AW-1:0]              rd_addr,
  input  logic [DW-1:0]              rd_data,
  output logic                       cw_valid,
  output logic [AW-1:0]              cw_addr,
  output logic [DW-1:0]              cw_data,
  input  logic                       cw_ready,
  output logic [$clog2(DEPTH+1)-1:0] sb_count,
  output logic                       sb_full,
  output logic                       sb_empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  // named internal events, observed by the checker
  logic push_evt, pop_evt, load_evt, fence_evt;

  logic [PTR_W-1:0]          head_ptr;
  logic [CNT_W-1:0]          occ;
  logic [DEPTH-1:0]          live;
  logic [DEPTH-1:0][AW-1:0]  slot_addr;
  logic [DEPTH-1:0][DW-1:0]  slot_data;
  logic                      fwd_hit;
  logic [DW-1:0]             fwd_data;

  assign sb_full  = (occ == CNT_W'(DEPTH));
  assign sb_empty = !live[head_ptr];
  assign sb_count = occ;

  wbuf_ctrl u_ctrl (
    .req_valid  (req_valid),
    .req_op     (req_op),
    .full       (sb_full),
    .empty      (sb_empty),
    .req_ready  (req_ready),
    .store_fire (push_evt),
    .load_fire  (load_evt),
    .fence_fire (fence_evt)
  );

  assign cw_valid = !sb_empty;
  assign cw_addr  = slot_addr[head_ptr];
  assign cw_data  = slot_data[head_ptr];
  assign pop_evt  = cw_valid && cw_ready;

  wbuf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_evt),
    .push_addr (req_addr),
    .push_data (req_wdata),
    .pop       (pop_evt),
    .head_ptr  (head_ptr),
    .occ       (occ),
    .live      (live),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  wbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .head_ptr  (head_ptr),
    .live      (live),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .look_addr (req_addr),
    .hit       (fwd_hit),
    .hit_data  (fwd_data)
  );

  assign rd_addr  = req_addr;
  assign ld_valid = load_evt;
  assign ld_hit   = load_evt && fwd_hit;
  assign ld_data  = fwd_hit ? fwd_data : rd_data;
endmodule

// File: rtl/wbuf_tso_chk.sv
module wbuf_tso_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic [1:0]                 req_op,
  input logic                       req_ready,
  input logic                       cw_valid,
  input logic [AW-1:0]              cw_addr,
  input logic [DW-1:0]              cw_data,
  input logic                       cw_ready,
  input logic [$clog2(DEPTH+1)-1:0] sb_count,
  input logic                       sb_full,
  input logic                       sb_empty,
  input logic                       push_evt,
  input logic                       pop_evt,
  input logic                       fence_evt
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sb_count) <= DEPTH);

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sb_full && req_valid && req_op == 2'b01 |-> !req_ready && !push_evt);

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt && !pop_evt |=> int'(sb_count) == int'($past(sb_count)) + 1);

  assert_hold_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready |=> cw_valid && $stable(cw_addr) && $stable(cw_data));

  assert_idle_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sb_empty |-> !cw_valid);

  assert_fence_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fence_evt |-> sb_empty);

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt && pop_evt |=> $stable(sb_count));
endmodule

bind wbuf_tso wbuf_tso_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_ready (req_ready),
  .cw_valid  (cw_valid),
  .cw_addr   (cw_addr),
  .cw_data   (cw_data),
  .cw_ready  (cw_ready),
  .sb_count  (sb_count),
  .sb_full   (sb_full),
  .sb_empty  (sb_empty),
  .push_evt  (push_evt),
  .pop_evt   (pop_evt),
  .fence_evt (fence_evt)
);

// File: tb/test_wbuf_tso.sv
`timescale 1ns/1ps
module test_wbuf_tso;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH+1);
  localparam real TCK  = 20.0;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, ld_valid, ld_hit;
  logic [31:0] ld_data, rd_addr, rd_data, cw_addr, cw_data;
  logic cw_valid, cw_ready = 0;
  logic [CW-1:0] sb_count;
  logic sb_full, sb_empty;

  logic [31:0] mem [16];
  logic [31:0] ref_a [$];
  logic [31:0] ref_d [$];
  int n_chk = 0, n_bad = 0;
  bit last_both = 0;

  always #(TCK/2) clk = ~clk;
  assign rd_data = mem[rd_addr[3:0]];

  wbuf_tso #(.DEPTH(DEPTH)) i_wbuf_tso (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_hit(ld_hit),
    .rd_addr(rd_addr), .rd_data(rd_data), .cw_valid(cw_valid),
    .cw_addr(cw_addr), .cw_data(cw_data), .cw_ready(cw_ready),
    .sb_count(sb_count), .sb_full(sb_full), .sb_empty(sb_empty));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check combinational and held state, update model
  task automatic tick(input bit v, input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] d, input bit crdy);
    bit exp_rdy, hit, both;
    logic [31:0] exp_d;
    int n;
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a; req_wdata = d; cw_ready = crdy;
    #2;
    n = ref_a.size();
    check(int'(sb_count) == n, last_both ? "R9 count after enqueue+drain" : "R2 count",
          sb_count, n);
    check(cw_valid == (n > 0), "R4 cw_valid", cw_valid, n > 0);
    check(sb_full == (n == DEPTH), "R3 full flag", sb_full, n == DEPTH);
    if (v) begin
      if (op == 2'b00) begin
        exp_rdy = 1;
        hit = 0; exp_d = mem[a[3:0]];
        for (int k = 0; k < n; k++) if (ref_a[k] == a) begin hit = 1; exp_d = ref_d[k]; end
        check(req_ready == 1, "R6 load ready", req_ready, 1);
        check(ld_valid == 1 && ld_hit == hit, hit ? "R7 hit flag" : "R6 miss flag", ld_hit, hit);
        check(ld_data == exp_d, hit ? "R7 youngest data" : "R6 cache data", ld_data, exp_d);
      end else if (op == 2'b01) begin
        exp_rdy = (n < DEPTH);
        check(req_ready == exp_rdy, exp_rdy ? "R2 store ready" : "R3 store blocked",
              req_ready, exp_rdy);
      end else begin
        exp_rdy = (n == 0);
        check(req_ready == exp_rdy, "R8 fence ready", req_ready, exp_rdy);
      end
    end else exp_rdy = 0;
    both = 0;
    if (n > 0 && crdy) begin
      check(cw_addr == ref_a[0], "R5 drain address order", cw_addr, ref_a[0]);
      check(cw_data == ref_d[0], "R5 drain data order", cw_data, ref_d[0]);
      mem[ref_a[0][3:0]] = ref_d[0];
      void'(ref_a.pop_front()); void'(ref_d.pop_front());
      both = 1;
    end
    if (v && op == 2'b01 && exp_rdy) begin
      ref_a.push_back(a); ref_d.push_back(d);
    end else both = 0;
    last_both = both;
  endtask

  initial begin : watchdog
    #(TCK * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h100 + i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // R1 reset state
    check(sb_count == 0, "R1 count", sb_count, 0);
    check(sb_empty == 1, "R1 empty", sb_empty, 1);
    check(sb_full == 0, "R1 full", sb_full, 0);
    check(cw_valid == 0, "R1 cw_valid", cw_valid, 0);

    // fill with drains blocked, colliding addresses (R2, R3, R7)
    for (int i = 0; i < DEPTH; i++) tick(1, 2'b01, i % 3, 32'hA0 + i, 0);
    tick(1, 2'b01, 5, 32'hBAD, 0);          // R3 blocked store
    tick(1, 2'b00, 5, 0, 0);                // R3 blocked store left nothing
    for (int a = 0; a < 4; a++) tick(1, 2'b00, a, 0, 0); // R7 youngest / R6 miss
    tick(1, 2'b10, 0, 0, 0);                // R8 fence held
    // R9 enqueue together with drain at full is blocked; drain one then push+pop
    tick(0, 2'b00, 0, 0, 1);
    tick(1, 2'b01, 9, 32'hC9, 1);           // R9 simultaneous
    tick(0, 2'b00, 0, 0, 0);
    // drain to empty, then fence passes (R8)
    for (int i = 0; i < DEPTH + 2; i++) tick(1, 2'b10, 0, 0, 1);
    tick(1, 2'b11, 0, 0, 0);

    // R6 load bypass: pending store to 1, load from 2 reads cache
    tick(1, 2'b01, 1, 32'h11, 0);
    tick(1, 2'b00, 2, 0, 0);
    tick(1, 2'b00, 1, 0, 0);

    // sweep: wrap the ring with stall windows and colliding addresses
    for (int i = 0; i < 600; i++) begin
      logic [1:0] op;
      op = (i % 7 == 6) ? 2'b10 : ((i % 3 == 0) ? 2'b00 : 2'b01);
      tick(i % 5 != 4, op, (i * 5) % 11, 32'h5000 + i, (i % 50 >= 12) && (i % 4 != 0));
    end
    for (int i = 0; i < DEPTH + 4; i++) tick(0, 2'b00, 0, 0, 1);
    tick(1, 2'b10, 0, 0, 1);
    check(sb_empty == 1, "R4 drained empty", sb_empty, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule